// File: doc/BRIEF.md
# Interleaved Configuration Command Parser

This block sits behind a serial word receiver and turns a stream of 32-bit configuration words into the settings used by a spectrum monitoring datapath. The words come in pairs: an address word names a target register, and the word after it carries the value for that target. Each value goes into a shadow register picked by its address. Until a terminating command arrives, nothing downstream sees any change.

The terminating command is the reserved address 0xFFFF sent in an address slot. It has no value word. When it is accepted, every shadow register is copied to its active register on the same clock edge, and a one-cycle update strobe tells the consumers that a new, consistent set of settings is in place. The active registers are decoded into named fields: the RF tuning word, the decimation-filter settings, the spectrum-processing settings and the energy-detection settings.

Words enter through a valid/ready handshake. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and for the first edge after it, and stays high from then on. A sender that sees `in_ready` low must hold its word and `in_valid` until the word is taken. Words offered while `in_valid` is low are never taken.

Top module: `cfg_cmd_parser`

## Requirements
- R1: While reset is held and after it is released, every active field reads zero and `upd_strobe` is low. `in_ready` is high from the second rising edge after reset release onward.
- R2: The first word accepted after reset is treated as an address. The types then alternate: after an address (other than the finish code) the next accepted word is a parameter, and after a parameter the next accepted word is an address. Cycles with `in_valid` low take no word and do not change the alternation.
- R3: A parameter sent to address 0x102 sets the tuning word to parameter bits [22:0].
- R4: A parameter sent to address 0x200 sets the decimation-filter fields: shift = bits [24:18], decimation factor = bits [17:5], bandwidth code = bits [4:0].
- R5: A parameter sent to address 0x300 sets the spectrum fields: point count = bits [29:18], log-scale select = bit [17], average count = bits [16:9], decimation count = bits [8:0].
- R6: A parameter sent to address 0x400 sets threshold = bits [15:0] and dwell = bits [5:0]. The two fields overlap in the low bits of the word.
- R7: An address word whose low 16 bits are 0xFFFF, accepted in an address slot, is the finish command and takes no parameter word. On the edge that accepts it, all active registers load from the shadows, and `upd_strobe` is high for exactly the following cycle. Each finish command gives exactly one strobe cycle.
- R8: Active fields change only together with a strobe. A parameter that has been accepted but not yet followed by a finish command does not show on any output.
- R9: A parameter that follows an address not in {0x102, 0x200, 0x300, 0x400, 0xFFFF} is dropped, and the next accepted word is still treated as an address.
- R10: Only bits [15:0] of an address word are decoded; bits [31:16] have no effect. A value of 0xFFFF in a parameter slot is data and does not act as a finish command.
- R11: A shadow register keeps its value across commits until it is written again, and the last value written before a finish command is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered on in_word |
| in_ready | output | 1 | Parser can take a word |
| in_word | input | 32 | Address or parameter word |
| tune_word | output | 23 | Active RF tuning word, 1 kHz units |
| cic_shift | output | 7 | Active decimation-filter output shift |
| cic_decim | output | 13 | Active decimation factor |
| bw_code | output | 5 | Active filter bandwidth code |
| fft_points | output | 12 | Active spectrum point count |
| db_sel | output | 1 | Active log-scale select |
| avg_count | output | 8 | Active number of frames to average |
| dec_count | output | 9 | Active spectrum decimation count |
| det_thresh | output | 16 | Active energy-detect threshold |
| dwell | output | 6 | Active dwell time |
| upd_strobe | output | 1 | One-cycle pulse after a commit |

## Verification
If the address/parameter phase slips by one word, a value word is taken as an address. Most such values decode as unknown, so a later finish command applies stale data, and a stray 0xFFFF value raises the strobe one cycle after it is accepted. If the latched target is wrong, a field other than the intended one changes at the next strobe. If a commit is missed or leaks, the outputs either stay stale or change with the strobe low, and this shows in the cycle right after the finish word is accepted. The bench runs every field group through commit and non-commit sequences, and the bound checker watches phase, strobe and field stability on every cycle.

// File: rtl/cfg_cmd_pkg.sv
`timescale 1ns/1ps
package cfg_cmd_pkg;

  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [ADDR_W-1:0] ADDR_TUNE   = 16'h0102;
  localparam logic [ADDR_W-1:0] ADDR_CIC    = 16'h0200;
  localparam logic [ADDR_W-1:0] ADDR_FFT    = 16'h0300;
  localparam logic [ADDR_W-1:0] ADDR_DET    = 16'h0400;
  localparam logic [ADDR_W-1:0] ADDR_FINISH = 16'hFFFF;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_TUNE = 2'd0,
    SLOT_CIC  = 2'd1,
    SLOT_FFT  = 2'd2,
    SLOT_DET  = 2'd3
  } slot_e;

  typedef struct packed {
    logic  hit;
    slot_e slot;
  } target_t;

  function automatic target_t decode_addr(input logic [ADDR_W-1:0] a);
    target_t t;
    t.hit  = 1'b1;
    t.slot = SLOT_TUNE;
    case (a)
      ADDR_TUNE: t.slot = SLOT_TUNE;
      ADDR_CIC:  t.slot = SLOT_CIC;
      ADDR_FFT:  t.slot = SLOT_FFT;
      ADDR_DET:  t.slot = SLOT_DET;
      default:   t.hit  = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/cfg_slot_seq.sv
`timescale 1ns/1ps
module cfg_slot_seq
  import cfg_cmd_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [WIDTH-1:0]  word,
  output logic              param_phase,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              commit
);

  target_t tgt_q;
  target_t tgt_d;
  logic    is_finish;

  assign tgt_d     = decode_addr(word[ADDR_W-1:0]);
  assign is_finish = (word[ADDR_W-1:0] == ADDR_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      param_phase <= 1'b0;
      tgt_q       <= '0;
    end else if (acc) begin
      if (param_phase) begin
        param_phase <= 1'b0;
      end else if (!is_finish) begin
        param_phase <= 1'b1;
        tgt_q       <= tgt_d;
      end
    end
  end

  assign wr_en   = acc & param_phase & tgt_q.hit;
  assign wr_slot = tgt_q.slot;
  assign commit  = acc & ~param_phase & is_finish;

endmodule

// File: rtl/cfg_shadow_bank.sv
`timescale 1ns/1ps
module cfg_shadow_bank #(
  parameter int NUM   = 4,
  parameter int WIDTH = 32,
  localparam int SW   = $clog2(NUM)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_slot,
  input  logic [WIDTH-1:0]          wr_data,
  output logic [NUM-1:0][WIDTH-1:0] shadow
);

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow[g] <= '0;
      else if (wr_en && (wr_slot == SW'(g)))
        shadow[g] <= wr_data;
    end
  end

endmodule

// File: rtl/cfg_active_bank.sv
`timescale 1ns/1ps
module cfg_active_bank #(
  parameter int NUM   = 4,
  parameter int WIDTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [NUM-1:0][WIDTH-1:0] shadow,
  output logic [NUM-1:0][WIDTH-1:0] active,
  output logic                      strobe
);

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        active[g] <= '0;
      else if (commit)
        active[g] <= shadow[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= commit;
  end

endmodule

// File: rtl/cfg_cmd_parser.sv
`timescale 1ns/1ps
module cfg_cmd_parser
  import cfg_cmd_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_word,
  output logic [22:0]      tune_word,
  output logic [6:0]       cic_shift,
  output logic [12:0]      cic_decim,
  output logic [4:0]       bw_code,
  output logic [11:0]      fft_points,
  output logic             db_sel,
  output logic [7:0]       avg_count,
  output logic [8:0]       dec_count,
  output logic [15:0]      det_thresh,
  output logic [5:0]       dwell,
  output logic             upd_strobe
);

  logic                            acc;
  logic                            param_phase;
  logic                            wr_en;
  logic [SLOT_W-1:0]               wr_slot;
  logic                            commit;
  logic [NUM_SLOTS-1:0][WIDTH-1:0] shadow;
  logic [NUM_SLOTS-1:0][WIDTH-1:0] active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign acc = in_valid & in_ready;

  cfg_slot_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .word(in_word),
    .param_phase(param_phase), .wr_en(wr_en), .wr_slot(wr_slot),
    .commit(commit)
  );

  cfg_shadow_bank #(.NUM(NUM_SLOTS), .WIDTH(WIDTH)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(in_word), .shadow(shadow)
  );

  cfg_active_bank #(.NUM(NUM_SLOTS), .WIDTH(WIDTH)) u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shadow(shadow),
    .active(active), .strobe(upd_strobe)
  );

  // Field unpacking of the committed words
  assign tune_word  = active[int'(SLOT_TUNE)][22:0];
  assign cic_shift  = active[int'(SLOT_CIC)][24:18];
  assign cic_decim  = active[int'(SLOT_CIC)][17:5];
  assign bw_code    = active[int'(SLOT_CIC)][4:0];
  assign fft_points = active[int'(SLOT_FFT)][29:18];
  assign db_sel     = active[int'(SLOT_FFT)][17];
  assign avg_count  = active[int'(SLOT_FFT)][16:9];
  assign dec_count  = active[int'(SLOT_FFT)][8:0];
  assign det_thresh = active[int'(SLOT_DET)][15:0];
  assign dwell      = active[int'(SLOT_DET)][5:0];

endmodule

// File: rtl/cfg_cmd_parser_chk.sv
`timescale 1ns/1ps
module cfg_cmd_parser_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_word,
  input logic             param_phase,
  input logic             upd_strobe,
  input logic [22:0]      tune_word,
  input logic [12:0]      cic_decim,
  input logic [11:0]      fft_points,
  input logic [15:0]      det_thresh
);

  logic acc;
  logic fin_word;
  assign acc      = in_valid & in_ready;
  assign fin_word = (in_word[15:0] == 16'hFFFF);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!upd_strobe && tune_word == '0 && det_thresh == '0));

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  assert_param_to_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && param_phase) |=> !param_phase);

  assert_addr_to_param_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !param_phase && !fin_word) |=> param_phase);

  assert_idle_keeps_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(param_phase));

  assert_finish_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !param_phase && fin_word) |=> upd_strobe);

  assert_strobe_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(acc && !param_phase && fin_word));

  assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |-> ($stable(tune_word) && $stable(cic_decim) &&
                     $stable(fft_points) && $stable(det_thresh)));

  assert_data_ffff_no_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && param_phase) |=> !upd_strobe);

endmodule

bind cfg_cmd_parser cfg_cmd_parser_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .param_phase(param_phase), .upd_strobe(upd_strobe),
  .tune_word(tune_word), .cic_decim(cic_decim), .fft_points(fft_points),
  .det_thresh(det_thresh)
);

// File: tb/tb_cfg_cmd_parser.sv
`timescale 1ns/1ps
module tb_cfg_cmd_parser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic [22:0] tune_word;
  logic [6:0]  cic_shift;
  logic [12:0] cic_decim;
  logic [4:0]  bw_code;
  logic [11:0] fft_points;
  logic        db_sel;
  logic [7:0]  avg_count;
  logic [8:0]  dec_count;
  logic [15:0] det_thresh;
  logic [5:0]  dwell;
  logic        upd_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_sh  [4];
  logic [31:0] exp_act [4];

  always #2 clk = ~clk;

  cfg_cmd_parser dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .tune_word(tune_word), .cic_shift(cic_shift),
    .cic_decim(cic_decim), .bw_code(bw_code), .fft_points(fft_points),
    .db_sel(db_sel), .avg_count(avg_count), .dec_count(dec_count),
    .det_thresh(det_thresh), .dwell(dwell), .upd_strobe(upd_strobe)
  );

  // {address[15:0], parameter[31:0], commit after pair}
  localparam logic [48:0] VECS [0:7] = '{
    {16'h0102, 32'hFF8A_3F21, 1'b1},
    {16'h0200, 32'h0196_ABCD, 1'b1},
    {16'h0300, 32'h3FFF_FFFF, 1'b0},
    {16'h0400, 32'h1234_5678, 1'b1},
    {16'h0102, 32'h0000_0000, 1'b0},
    {16'h0300, 32'h1005_4321, 1'b1},
    {16'h0200, 32'hFFFF_FFFF, 1'b1},
    {16'h0400, 32'h0000_003F, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({"R3 tune ", ctx},   32'(tune_word),  32'(exp_act[0][22:0]));
    chk({"R4 shift ", ctx},  32'(cic_shift),  32'(exp_act[1][24:18]));
    chk({"R4 decim ", ctx},  32'(cic_decim),  32'(exp_act[1][17:5]));
    chk({"R4 bw ", ctx},     32'(bw_code),    32'(exp_act[1][4:0]));
    chk({"R5 points ", ctx}, 32'(fft_points), 32'(exp_act[2][29:18]));
    chk({"R5 db ", ctx},     32'(db_sel),     32'(exp_act[2][17]));
    chk({"R5 avg ", ctx},    32'(avg_count),  32'(exp_act[2][16:9]));
    chk({"R5 dec ", ctx},    32'(dec_count),  32'(exp_act[2][8:0]));
    chk({"R6 thresh ", ctx}, 32'(det_thresh), 32'(exp_act[3][15:0]));
    chk({"R6 dwell ", ctx},  32'(dwell),      32'(exp_act[3][5:0]));
  endtask

  // Drive at a falling edge, return at the next falling edge (word taken in between).
  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'hFFFF_FFFF;
  endtask

  function automatic int slot_of(input logic [15:0] a);
    case (a)
      16'h0102: return 0;
      16'h0200: return 1;
      16'h0300: return 2;
      16'h0400: return 3;
      default:  return -1;
    endcase
  endfunction

  task automatic send_pair(input logic [31:0] a, input logic [31:0] p);
    int s;
    send_word(a);
    send_word(p);
    s = slot_of(a[15:0]);
    if (s >= 0) exp_sh[s] = p;
  endtask

  task automatic finish_and_check(input string ctx);
    send_word(32'h0000_FFFF);
    chk({"R7 strobe high ", ctx}, 32'(upd_strobe), 32'd1);
    for (int i = 0; i < 4; i++) exp_act[i] = exp_sh[i];
    check_all(ctx);
    @(negedge clk);
    chk({"R7 strobe one cycle ", ctx}, 32'(upd_strobe), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin exp_sh[i] = '0; exp_act[i] = '0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", 32'(upd_strobe), 32'd0);
    chk("R1 ready in reset", 32'(in_ready), 32'd0);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after reset", 32'(in_ready), 32'd1);
    chk("R1 strobe after reset", 32'(upd_strobe), 32'd0);

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      send_pair({16'h0000, VECS[v][48:33]}, VECS[v][32:1]);
      if (VECS[v][0]) begin
        finish_and_check($sformatf("R11 vec%0d", v));
      end else begin
        @(negedge clk);
        chk($sformatf("R8 no strobe vec%0d", v), 32'(upd_strobe), 32'd0);
        check_all($sformatf("R8 held vec%0d", v));
      end
    end

    // R2: idle cycles carrying a finish code are not taken and keep the phase
    @(negedge clk);
    in_valid = 1'b0; in_word = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    chk("R2 idle finish not taken", 32'(upd_strobe), 32'd0);
    send_word(32'h0000_0102);
    repeat (2) @(negedge clk);
    chk("R2 idle between addr and param", 32'(upd_strobe), 32'd0);
    send_word(32'h0044_4444);
    exp_sh[0] = 32'h0044_4444;
    finish_and_check("R2 gap");

    // R9: unknown address drops its value (0xFFFF here) and keeps alternation
    send_word(32'h0000_0555);
    send_word(32'h0000_FFFF);
    chk("R9 dropped ffff no strobe", 32'(upd_strobe), 32'd0);
    @(negedge clk);
    chk("R9 dropped ffff no strobe later", 32'(upd_strobe), 32'd0);
    send_pair(32'h0000_0102, 32'h0000_1111);
    finish_and_check("R9 after unknown");

    // R10: upper address bits ignored
    send_pair(32'hABCD_0102, 32'h0000_2222);
    exp_sh[0] = 32'h0000_2222;
    finish_and_check("R10 upper bits");

    // R10: 0xFFFF in a parameter slot is data
    send_word(32'h0000_0400);
    send_word(32'h0000_FFFF);
    exp_sh[3] = 32'h0000_FFFF;
    chk("R10 ffff param no strobe", 32'(upd_strobe), 32'd0);
    @(negedge clk);
    chk("R10 ffff param no strobe later", 32'(upd_strobe), 32'd0);
    chk("R10 thresh held before finish", 32'(det_thresh), 32'(exp_act[3][15:0]));
    finish_and_check("R10 ffff data");

    // R7: finish needs no parameter; back-to-back finishes, then an address
    finish_and_check("R7 repeat finish");
    send_pair(32'h0000_0102, 32'h0000_3333);
    finish_and_check("R7 addr after finish");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule